// File: doc/BRIEF.md
# Audio Codec Link Frame Transmitter

This block drives the outgoing half of a serial audio-codec link. The external codec supplies the bit clock, and the block runs directly on that clock. Each frame is 256 bits long. It opens with a 16-bit tag slot and continues with twelve 20-bit data slots. Every slot is sent most-significant bit first, and the serial output is updated once per rising bit-clock edge.

At the start of each frame the block samples a per-slot availability vector. From that vector it builds the tag word. For every slot marked as available, the block asks its upstream source for one 20-bit word with a ready/valid handshake. The request is raised during the last bit before that slot begins. The block also generates the frame sync, which rises one bit ahead of the tag slot and covers the tag.

While the link is inactive, the frame position is held in a parked state. The serial output stays low, and the sync pin copies a static level from an input.

Top module: `codec_frame_tx`

## Requirements
- R1: While `rst` is high, `sdata_out`, `sync_out` and `slot_ready` are all 0 from the next clock edge on.
- R2: When the link is active, each frame on `sdata_out` is 256 bits: the 16-bit tag, then slots 1 to 12 of 20 bits each. Every slot is sent MSB first, and the output changes once per rising clock edge. The first frame begins with the first edge at which `link_active` is high.
- R3: When the link is active, `sync_out` is high for frame bit positions 255 and 0 to 14, which is 16 cycles covering the tag slot. It is low elsewhere, so consecutive rises are 256 cycles apart. In the first frame after activation, only positions 0 to 14 are high. `sync_force` has no effect while the link is active.
- R4: The tag word uses `slot_avail` as sampled on the edge that starts the frame. Bit 15 is the OR of all availability bits. Bit 14-(k-1) flags slot k for k = 1 to 12, so `slot_avail[0]` drives bit 14 and `slot_avail[11]` drives bit 3. Bits 2 to 0 are 0.
- R5: For each available slot k, `slot_ready` is high for exactly one cycle: the cycle in which the last bit of the preceding slot is on `sdata_out`. During that cycle `slot_index` equals k. The word on `slot_data` is taken at the next edge when `slot_valid` is high.
- R6: An available slot whose `slot_valid` is low during its request cycle is sent as 20 zero bits.
- R7: A slot that is not available in the tag is never requested. It is sent as 20 zero bits, whatever `slot_data` and `slot_valid` hold.
- R8: While `link_active` is low, `sync_out` takes the value of `sync_force` one edge later, and `sdata_out` is 0.
- R9: `slot_ready` is never high while `link_active` is low. When it is high, `slot_index` lies between 1 and 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Codec-supplied bit clock |
| rst | input | 1 | Synchronous active-high reset |
| link_active | input | 1 | Frame generation enable |
| sync_force | input | 1 | Static sync level used while the link is inactive |
| slot_avail | input | 12 | Per-slot availability, bit 0 = slot 1, sampled at frame start |
| slot_data | input | 20 | Data word for the requested slot |
| slot_valid | input | 1 | `slot_data` holds a word for the requested slot |
| slot_ready | output | 1 | Request for the slot named by `slot_index` |
| slot_index | output | 4 | Number of the slot requested (1 to 12), 0 when idle |
| sdata_out | output | 1 | Serial frame data |
| sync_out | output | 1 | Frame sync |

## Verification
A wrong slot or bit counter appears at the ports within one slot. The request strobe and `slot_index` land on the wrong bit position, and in the same frame the deserialised words shift out of alignment with the tag. A corrupt latched availability vector shows up as a request pattern that disagrees with the tag sent in that same frame. A stale shift register shows up as nonzero bits in slots that should be silent. A sync timing error shows up at the frame boundary, as a rise that is not 256 cycles after the previous one or as a high phase that is not 16 bits long.

// File: rtl/cft_pkg.sv
package cft_pkg;
  localparam int DEF_TAG_W   = 16;
  localparam int DEF_SLOT_W  = 20;
  localparam int DEF_N_SLOTS = 12;

  function automatic int frame_len(int tag_w, int slot_w, int n_slots);
    return tag_w + slot_w * n_slots;
  endfunction
endpackage

// File: rtl/cft_timing.sv
// Frame position tracker: slot number (0 = tag) and bit within the slot.
module cft_timing #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12,
  parameter int SW      = 4,
  parameter int BW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_active,
  output logic [SW-1:0] nslot,
  output logic [BW-1:0] nbit,
  output logic          at_last
);
  localparam logic [BW-1:0] TAG_LAST  = BW'(TAG_W - 1);
  localparam logic [BW-1:0] SLOT_LAST = BW'(SLOT_W - 1);
  localparam logic [SW-1:0] SLOT_MAX  = SW'(N_SLOTS);

  logic [SW-1:0] slot_q;
  logic [BW-1:0] bit_q;

  always_comb begin
    at_last = (slot_q == '0) ? (bit_q == TAG_LAST) : (bit_q == SLOT_LAST);
    if (at_last) begin
      nslot = (slot_q == SLOT_MAX) ? '0 : slot_q + 1'b1;
      nbit  = '0;
    end else begin
      nslot = slot_q;
      nbit  = bit_q + 1'b1;
    end
  end

  // Parked on the final bit of a frame so activation starts at tag bit 0.
  always_ff @(posedge clk) begin
    if (rst || !link_active) begin
      slot_q <= SLOT_MAX;
      bit_q  <= SLOT_LAST;
    end else begin
      slot_q <= nslot;
      bit_q  <= nbit;
    end
  end
endmodule

// File: rtl/cft_tag_gen.sv
// Builds the tag word from the availability flags.
module cft_tag_gen #(
  parameter int TAG_W   = 16,
  parameter int N_SLOTS = 12
) (
  input  logic [N_SLOTS-1:0] avail,
  output logic [TAG_W-1:0]   tag
);
  always_comb begin
    tag          = '0;
    tag[TAG_W-1] = |avail;
    for (int k = 0; k < N_SLOTS; k++) begin
      tag[TAG_W-2-k] = avail[k];
    end
  end
endmodule

// File: rtl/cft_shifter.sv
// Parallel-load, MSB-first serialiser with a registered output bit.
module cft_shifter #(
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_active,
  input  logic              load,
  input  logic [SLOT_W-1:0] load_word,
  output logic              sdata
);
  logic [SLOT_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst || !link_active) begin
      sh_q  <= '0;
      sdata <= 1'b0;
    end else if (load) begin
      sdata <= load_word[SLOT_W-1];
      sh_q  <= {load_word[SLOT_W-2:0], 1'b0};
    end else begin
      sdata <= sh_q[SLOT_W-1];
      sh_q  <= {sh_q[SLOT_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/codec_frame_tx.sv
module codec_frame_tx #(
  parameter int TAG_W   = cft_pkg::DEF_TAG_W,
  parameter int SLOT_W  = cft_pkg::DEF_SLOT_W,
  parameter int N_SLOTS = cft_pkg::DEF_N_SLOTS
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           link_active,
  input  logic                           sync_force,
  input  logic [N_SLOTS-1:0]             slot_avail,
  input  logic [SLOT_W-1:0]              slot_data,
  input  logic                           slot_valid,
  output logic                           slot_ready,
  output logic [$clog2(N_SLOTS+1)-1:0]   slot_index,
  output logic                           sdata_out,
  output logic                           sync_out
);
  localparam int SW = $clog2(N_SLOTS + 1);
  localparam int BW = $clog2((SLOT_W > TAG_W) ? SLOT_W : TAG_W);
  localparam logic [SW-1:0] SLOT_MAX  = SW'(N_SLOTS);
  localparam logic [BW-1:0] TAG_LAST  = BW'(TAG_W - 1);
  localparam logic [BW-1:0] SLOT_LAST = BW'(SLOT_W - 1);

  logic [SW-1:0]      nslot;
  logic [BW-1:0]      nbit;
  logic               at_last;
  logic [TAG_W-1:0]   tag_word;
  logic [N_SLOTS-1:0] flags_q;
  logic [N_SLOTS:0]   flag_ext;
  logic               tag_load, any_load;
  logic [SLOT_W-1:0]  load_word;

  cft_timing #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS), .SW(SW), .BW(BW)
  ) i_timing (
    .clk(clk), .rst(rst), .link_active(link_active),
    .nslot(nslot), .nbit(nbit), .at_last(at_last)
  );

  cft_tag_gen #(.TAG_W(TAG_W), .N_SLOTS(N_SLOTS)) i_tag (
    .avail(slot_avail), .tag(tag_word)
  );

  assign tag_load = (nslot == '0) && (nbit == '0);
  assign any_load = (nbit == '0);
  assign flag_ext = {flags_q, 1'b0};

  // Request the upcoming slot during the last bit of the current one.
  assign slot_ready = link_active && at_last && (nslot != '0) && flag_ext[nslot];
  assign slot_index = slot_ready ? nslot : '0;

  always_comb begin
    if (tag_load)
      load_word = SLOT_W'(tag_word) << (SLOT_W - TAG_W);
    else if (slot_ready && slot_valid)
      load_word = slot_data;
    else
      load_word = '0;
  end

  cft_shifter #(.SLOT_W(SLOT_W)) i_shift (
    .clk(clk), .rst(rst), .link_active(link_active),
    .load(any_load), .load_word(load_word), .sdata(sdata_out)
  );

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else if (link_active && tag_load)
      flags_q <= slot_avail;
  end

  always_ff @(posedge clk) begin
    if (rst)
      sync_out <= 1'b0;
    else if (!link_active)
      sync_out <= sync_force;
    else
      sync_out <= ((nslot == '0) && (nbit < TAG_LAST)) ||
                  ((nslot == SLOT_MAX) && (nbit == SLOT_LAST));
  end
endmodule

// File: rtl/cft_checker.sv
module cft_checker #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int N_SLOTS = 12
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         link_active,
  input logic                         sync_force,
  input logic                         slot_ready,
  input logic [$clog2(N_SLOTS+1)-1:0] slot_index,
  input logic                         sdata_out,
  input logic                         sync_out
);
  localparam int FRAME = cft_pkg::frame_len(TAG_W, SLOT_W, N_SLOTS);
  localparam int CW    = $clog2(FRAME + 1);

  logic          sync_d;
  logic [1:0]    rises;
  logic [CW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst || !link_active) begin
      sync_d <= 1'b0;
      rises  <= '0;
      gap    <= '0;
    end else begin
      sync_d <= sync_out;
      if (sync_out && !sync_d) begin
        gap <= '0;
        if (rises != 2'd2) rises <= rises + 1'b1;
      end else begin
        gap <= gap + 1'b1;
      end
    end
  end

  AST_READY_NEEDS_LINK: assert property (@(posedge clk) disable iff (rst)
    slot_ready |-> link_active);                                             // R9
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
    slot_ready |-> (slot_index >= 1 && slot_index <= N_SLOTS));              // R9
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    slot_ready |=> !slot_ready);                                             // R5
  AST_IDLE_SYNC: assert property (@(posedge clk) disable iff (rst)
    !link_active |=> sync_out == $past(sync_force));                         // R8
  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (rst)
    !link_active |=> !sdata_out);                                            // R8
  AST_SYNC_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (link_active && $past(link_active) && sync_out && !sync_d && rises == 2'd2)
      |-> gap == CW'(FRAME - 1));                                            // R3
endmodule

bind codec_frame_tx cft_checker #(
  .TAG_W(TAG_W), .SLOT_W(SLOT_W), .N_SLOTS(N_SLOTS)
) i_cft_checker (
  .clk(clk), .rst(rst), .link_active(link_active), .sync_force(sync_force),
  .slot_ready(slot_ready), .slot_index(slot_index),
  .sdata_out(sdata_out), .sync_out(sync_out)
);

// File: tb/test_codec_frame_tx.sv
module test_codec_frame_tx;
  localparam int NS = 12;
  localparam int NFR = 17;

  logic        clk = 1'b0;
  logic        rst, link_active, sync_force, slot_valid, slot_ready;
  logic [11:0] slot_avail, vmask;
  logic [19:0] slot_data;
  logic [3:0]  slot_index;
  logic        sdata_out, sync_out;
  int          fnum;
  int          errors = 0, checks = 0;
  bit          done = 0;
  logic [12:0] vext;

  always #5 clk = ~clk;

  function automatic logic [19:0] pat(int f, int k);
    return 20'((f * 37 + 1) * 20'h0B3C5) ^ 20'(k * 20'h01111) ^ 20'(k << 16);
  endfunction

  assign vext       = {vmask, 1'b0};
  assign slot_data  = pat(fnum, int'(slot_index));
  assign slot_valid = vext[slot_index];

  codec_frame_tx i_codec_frame_tx (
    .clk(clk), .rst(rst), .link_active(link_active), .sync_force(sync_force),
    .slot_avail(slot_avail), .slot_data(slot_data), .slot_valid(slot_valid),
    .slot_ready(slot_ready), .slot_index(slot_index),
    .sdata_out(sdata_out), .sync_out(sync_out)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic set_cfg(int f);
    fnum = f;
    case (f)
      0: begin slot_avail = 12'hFFF; vmask = 12'hFFF; end
      1: begin slot_avail = 12'hA5A; vmask = 12'hFFF; end
      2: begin slot_avail = 12'hFFF; vmask = 12'h3C3; end
      3: begin slot_avail = 12'h000; vmask = 12'hFFF; end
      4: begin slot_avail = 12'h801; vmask = 12'hFFF; end
      default: begin
        slot_avail = 12'(1 << (f - 5));
        vmask = ((f - 5) % 2 == 1) ? 12'hFFF : ~12'(1 << (f - 5));
      end
    endcase
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    logic sd [256];
    logic sy [256];
    int   rdy_bad;
    logic [15:0] tag_act, tag_exp;
    logic [19:0] w_act, w_exp;
    logic [11:0] av, vm;
    rst = 1; link_active = 0; sync_force = 0; slot_avail = 0; vmask = 0; fnum = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sdata_out == 0 && sync_out == 0 && slot_ready == 0, "R1", "reset outputs",
        {sdata_out, sync_out, slot_ready}, 0);
    rst = 0;

    // Inactive link: sync follows the static level.
    for (int i = 0; i < 4; i++) begin
      sync_force = i[0] ^ 1'b1;
      @(negedge clk);
      chk(sync_out == sync_force, "R8", "idle sync", sync_out, sync_force);
      chk(sdata_out == 0, "R8", "idle data", sdata_out, 0);
      chk(slot_ready == 0, "R9", "idle ready", slot_ready, 0);
    end

    sync_force = 1;  // must be ignored while active (R3)
    set_cfg(0);
    link_active = 1;
    for (int f = 0; f < NFR; f++) begin
      av = slot_avail; vm = vmask;
      rdy_bad = 0;
      for (int p = 0; p < 256; p++) begin
        int kexp;
        @(negedge clk);
        sd[p] = sdata_out; sy[p] = sync_out;
        kexp = 0;
        for (int k = 1; k <= NS; k++)
          if (p == 15 + 20 * (k - 1) && av[k-1]) kexp = k;
        if (slot_ready != (kexp != 0) || int'(slot_index) != kexp) rdy_bad++;
        if (p == 255) begin
          if (f + 1 < NFR) set_cfg(f + 1);
          else link_active = 0;
        end
      end
      chk(rdy_bad == 0, "R5", $sformatf("request timing frame %0d", f), rdy_bad, 0);
      // R3: sync at positions 0..14 and 255
      begin
        int sbad = 0;
        for (int p = 0; p < 256; p++)
          if (sy[p] != ((p < 15) || (p == 255))) sbad++;
        chk(sbad == 0, "R3", $sformatf("sync shape frame %0d", f), sbad, 0);
      end
      // R4: tag deserialised from bits 0..15
      tag_exp = '0;
      tag_exp[15] = |av;
      for (int k = 0; k < NS; k++) tag_exp[14-k] = av[k];
      for (int b = 0; b < 16; b++) tag_act[15-b] = sd[b];
      chk(tag_act == tag_exp, "R4", $sformatf("tag frame %0d", f), tag_act, tag_exp);
      // R2/R6/R7: slot words, MSB first
      for (int k = 1; k <= NS; k++) begin
        for (int b = 0; b < 20; b++) w_act[19-b] = sd[16 + 20 * (k - 1) + b];
        if (!av[k-1]) begin
          chk(w_act == 0, "R7", $sformatf("unflagged slot %0d frame %0d", k, f), w_act, 0);
        end else if (!vm[k-1]) begin
          chk(w_act == 0, "R6", $sformatf("invalid slot %0d frame %0d", k, f), w_act, 0);
        end else begin
          w_exp = pat(f, k);
          chk(w_act == w_exp, "R2", $sformatf("slot %0d frame %0d", k, f), w_act, w_exp);
        end
      end
    end
    @(negedge clk);
    chk(sync_out == 1 && sdata_out == 0, "R8", "deactivated sync level",
        {sync_out, sdata_out}, 2);
    sync_force = 0;
    @(negedge clk);
    chk(sync_out == 0, "R8", "deactivated sync low", sync_out, 0);
    chk(slot_ready == 0, "R9", "no request after stop", slot_ready, 0);
    summary();
  end
endmodule